// File: doc/BRIEF.md
# Class-Partitioned Virtual Channel Allocator

This block picks the downstream virtual channel for each packet leaving one output port of a network router. Several input ports may compete for the same output in a cycle. Each one presents a message class, an ordering flag and a flag from the route computation that says whether the hop is past the ring's wrap edge. The block answers in the same cycle with a grant and the index of the channel the packet will use.

Each of the six ordinary message classes has three private channels: one adaptive channel and two escape channels that are free of deadlock. A seventh, special class has one channel. There are 19 channels in all. The adaptive channel is tried first. When it has no buffer space, the packet goes to the escape channel that its wrap position selects. Buffer space is tracked with a credit counter for each channel. A grant spends a credit and a return pulse from the downstream router adds one back. The block also keeps I/O reads from overtaking I/O writes. When several inputs pick the same channel, a round-robin arbiter for that channel chooses one winner.

Top module: `vc_alloc`

## Requirements
- R1: After reset every channel holds CREDIT_MAX credits, no grant is given without a request, and the first request of an ordinary class is granted its adaptive channel.
- R2: Channel numbering: class c in 0..5 owns adaptive channel 3c, escape channel 3c+1 and escape channel 3c+2. Class 6 owns channel 18 only. Class 7 is invalid and is never granted. Class codes are 3 bits wide on reqClass, in slot i*3.
- R3: A request that is not marked in-order goes to its adaptive channel whenever that channel holds at least one credit.
- R4: When the adaptive channel has no credit, the request targets an escape channel: 3c+1 when reqWrapped is 0 and 3c+2 when reqWrapped is 1.
- R5: A request with reqInOrder set never uses the adaptive channel. It targets the escape channel chosen as in R4, even when the adaptive channel has credit.
- R6: No grant is given when the targeted channel has zero credit. An empty channel of one class never stops a grant to another class.
- R7: Each grant spends one credit of its channel and each creditReturn pulse adds one back. A return together with a grant leaves the count unchanged. Returns at CREDIT_MAX are ignored, so a full channel accepts exactly CREDIT_MAX grants in a row.
- R8: Class 4 is I/O read and class 5 is I/O write. An I/O read is not granted in any cycle in which a valid I/O write request is present on any input. I/O writes are never held back by reads.
- R9: When several eligible inputs target the same channel, one of them is granted. Priority rotates: the search starts just after the last winner on that channel and begins at input 0 after reset.
- R10: A grant appears only for a valid request, and at most one input is granted any one channel in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_IN | A packet waits at input i |
| reqClass | input | NUM_IN*3 | Message class per input, 3 bits each |
| reqInOrder | input | NUM_IN | The packet must stay ordered and take an escape channel |
| reqWrapped | input | NUM_IN | The route is past the ring's wrap edge |
| creditReturn | input | 19 | One credit returned per channel, as a pulse |
| grantValid | output | NUM_IN | Input i is granted this cycle |
| grantVc | output | NUM_IN*5 | Granted channel index per input, 5 bits each, zero when not granted |

## Verification
The bench builds the block with NUM_IN=3 and CREDIT_MAX=2. With a credit depth of two, a channel runs dry after two grants, so the fallback to the escape channels, the exhaustion of a whole class and the saturation of returns each take only a few cycles. Three inputs, a count that is not a power of two, make the round-robin pointer wrap through its modulo step, and they let reads, writes and a contested channel meet in the same cycle.

// File: rtl/vc_alloc_pkg.sv
package vc_alloc_pkg;
  localparam int NUM_ORD_CLASS = 6;
  localparam int VC_PER_CLASS  = 3;
  localparam int NUM_VC        = NUM_ORD_CLASS * VC_PER_CLASS + 1;
  localparam int VC_W          = $clog2(NUM_VC);
  localparam int CLS_W         = 3;
  localparam int SPECIAL_CLASS = NUM_ORD_CLASS;
  localparam int IO_RD_CLASS   = 4;
  localparam int IO_WR_CLASS   = 5;
  localparam int SPECIAL_VC    = NUM_VC - 1;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_VC-1:0] consume;
  } alloc_strobe_t;

  function automatic logic [VC_W-1:0] adaptiveVc(input logic [CLS_W-1:0] cls);
    return VC_W'(VC_PER_CLASS * int'(cls));
  endfunction

  function automatic logic [VC_W-1:0] escapeVc(input logic [CLS_W-1:0] cls,
                                               input logic wrapped);
    return VC_W'(VC_PER_CLASS * int'(cls) + 1 + int'(wrapped));
  endfunction
endpackage

// File: rtl/vc_alloc_rr_arb.sv
module vc_alloc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] nextPtr;
  logic          found;

  always_comb begin
    gnt     = '0;
    found   = 1'b0;
    nextPtr = ptr;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        found   = 1'b1;
        gnt[idx] = 1'b1;
        nextPtr = (idx + 1 == N) ? '0 : PW'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= nextPtr;
  end
endmodule

// File: rtl/vc_alloc_datapath.sv
module vc_alloc_datapath import vc_alloc_pkg::*; #(
  parameter int CREDIT_MAX = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  alloc_strobe_t       strobes,
  input  logic [NUM_VC-1:0]   creditReturn,
  output logic [NUM_VC-1:0]   vcAvail
);
  localparam int CW = $clog2(CREDIT_MAX + 1);
  localparam logic [CW-1:0] FULL = CW'(CREDIT_MAX);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_cred
    logic [CW-1:0] credCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        credCnt <= FULL;
      end else begin
        unique case ({strobes.consume[v], creditReturn[v]})
          2'b10:   credCnt <= credCnt - 1'b1;
          2'b01:   credCnt <= (credCnt == FULL) ? credCnt : credCnt + 1'b1;
          default: credCnt <= credCnt;
        endcase
      end
    end

    assign vcAvail[v] = (credCnt != '0);
  end
endmodule

// File: rtl/vc_alloc_ctrl.sv
module vc_alloc_ctrl import vc_alloc_pkg::*; #(
  parameter int NUM_IN = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_IN-1:0]       reqValid,
  input  logic [NUM_IN*CLS_W-1:0] reqClass,
  input  logic [NUM_IN-1:0]       reqInOrder,
  input  logic [NUM_IN-1:0]       reqWrapped,
  input  logic [NUM_VC-1:0]       vcAvail,
  output alloc_strobe_t           strobes,
  output logic [NUM_IN-1:0]       grantValid,
  output logic [NUM_IN*VC_W-1:0]  grantVc
);
  logic [VC_W-1:0]   tgtVc [NUM_IN];
  logic [NUM_IN-1:0] eligible;
  logic              anyWrite;
  logic [NUM_IN-1:0] arbReq [NUM_VC];
  logic [NUM_IN-1:0] arbGnt [NUM_VC];

  always_comb begin
    anyWrite = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (reqValid[i] && reqClass[i*CLS_W +: CLS_W] == CLS_W'(IO_WR_CLASS))
        anyWrite = 1'b1;
    end
  end

  // target channel selection per input
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      logic [CLS_W-1:0] cls;
      cls         = reqClass[i*CLS_W +: CLS_W];
      tgtVc[i]    = '0;
      eligible[i] = 1'b0;
      if (reqValid[i]) begin
        if (cls == CLS_W'(SPECIAL_CLASS)) begin
          tgtVc[i]    = VC_W'(SPECIAL_VC);
          eligible[i] = vcAvail[SPECIAL_VC];
        end else if (int'(cls) < NUM_ORD_CLASS) begin
          if (!reqInOrder[i] && vcAvail[adaptiveVc(cls)])
            tgtVc[i] = adaptiveVc(cls);
          else
            tgtVc[i] = escapeVc(cls, reqWrapped[i]);
          eligible[i] = vcAvail[tgtVc[i]];
          if (cls == CLS_W'(IO_RD_CLASS) && anyWrite)
            eligible[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        arbReq[v][i] = eligible[i] && (tgtVc[i] == VC_W'(v));
      end
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_arb
    vc_alloc_rr_arb #(.N(NUM_IN)) u_arb (
      .clk  (clk),
      .rstN (rstN),
      .req  (arbReq[v]),
      .gnt  (arbGnt[v])
    );
  end

  always_comb begin
    grantValid = '0;
    strobes    = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      strobes.consume[v] = |arbGnt[v];
      grantValid         = grantValid | arbGnt[v];
    end
    for (int i = 0; i < NUM_IN; i++) begin
      grantVc[i*VC_W +: VC_W] = grantValid[i] ? tgtVc[i] : '0;
    end
  end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc import vc_alloc_pkg::*; #(
  parameter int NUM_IN     = 4,
  parameter int CREDIT_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_IN-1:0]       reqValid,
  input  logic [NUM_IN*CLS_W-1:0] reqClass,
  input  logic [NUM_IN-1:0]       reqInOrder,
  input  logic [NUM_IN-1:0]       reqWrapped,
  input  logic [NUM_VC-1:0]       creditReturn,
  output logic [NUM_IN-1:0]       grantValid,
  output logic [NUM_IN*VC_W-1:0]  grantVc
);
  alloc_strobe_t     strobes;
  logic [NUM_VC-1:0] vcAvail;

  vc_alloc_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqClass   (reqClass),
    .reqInOrder (reqInOrder),
    .reqWrapped (reqWrapped),
    .vcAvail    (vcAvail),
    .strobes    (strobes),
    .grantValid (grantValid),
    .grantVc    (grantVc)
  );

  vc_alloc_datapath #(.CREDIT_MAX(CREDIT_MAX)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .creditReturn (creditReturn),
    .vcAvail      (vcAvail)
  );
endmodule

// File: rtl/vc_alloc_chk.sv
module vc_alloc_chk import vc_alloc_pkg::*; #(
  parameter int NUM_IN = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_IN-1:0]       reqValid,
  input logic [NUM_IN*CLS_W-1:0] reqClass,
  input logic [NUM_IN-1:0]       reqInOrder,
  input logic [NUM_IN-1:0]       reqWrapped,
  input logic [NUM_IN-1:0]       grantValid,
  input logic [NUM_IN*VC_W-1:0]  grantVc
);
  logic [NUM_IN-1:0] hit [NUM_VC];
  logic              wrSeen;

  always_comb begin
    wrSeen = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (reqValid[i] && reqClass[i*CLS_W +: CLS_W] == CLS_W'(IO_WR_CLASS)) wrSeen = 1'b1;
    end
    for (int v = 0; v < NUM_VC; v++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        hit[v][i] = grantValid[i] && (grantVc[i*VC_W +: VC_W] == VC_W'(v));
      end
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    p_single_winner_r10: assert property (@(posedge clk) disable iff (!rstN)
      $countones(hit[v]) <= 1);
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [CLS_W-1:0] cls;
    logic [VC_W-1:0]  vc;
    assign cls = reqClass[i*CLS_W +: CLS_W];
    assign vc  = grantVc[i*VC_W +: VC_W];

    p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> reqValid[i]);

    p_class_map_r2: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> ((int'(cls) == SPECIAL_CLASS && int'(vc) == SPECIAL_VC) ||
                         (int'(cls) < NUM_ORD_CLASS && int'(vc) / VC_PER_CLASS == int'(cls))));

    p_in_order_escape_r5: assert property (@(posedge clk) disable iff (!rstN)
      (grantValid[i] && reqInOrder[i] && int'(cls) < NUM_ORD_CLASS)
        |-> (int'(vc) % VC_PER_CLASS != 0));

    p_wrap_select_r4: assert property (@(posedge clk) disable iff (!rstN)
      (grantValid[i] && int'(cls) < NUM_ORD_CLASS && int'(vc) % VC_PER_CLASS != 0)
        |-> ((int'(vc) % VC_PER_CLASS == 2) == reqWrapped[i]));

    p_read_behind_write_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrSeen && int'(cls) == IO_RD_CLASS) |-> !grantValid[i]);
  end
endmodule

bind vc_alloc vc_alloc_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqClass   (reqClass),
  .reqInOrder (reqInOrder),
  .reqWrapped (reqWrapped),
  .grantValid (grantValid),
  .grantVc    (grantVc)
);

// File: tb/vc_alloc_bench.sv
`timescale 1ns/100ps
module vc_alloc_bench;
  localparam int NI  = 3;
  localparam int CM  = 2;
  localparam int TVC = 19;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NI-1:0]   reqValid;
  logic [NI*3-1:0] reqClass;
  logic [NI-1:0]   reqInOrder;
  logic [NI-1:0]   reqWrapped;
  logic [TVC-1:0]  creditReturn;
  logic [NI-1:0]   grantValid;
  logic [NI*5-1:0] grantVc;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int mCred [TVC];
  int mPtr  [TVC];
  int expTgt [NI];
  bit expElig[NI];
  bit expGv [NI];

  always #2 clk = ~clk;

  vc_alloc #(.NUM_IN(NI), .CREDIT_MAX(CM)) u_vc_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass),
    .reqInOrder(reqInOrder), .reqWrapped(reqWrapped), .creditReturn(creditReturn),
    .grantValid(grantValid), .grantVc(grantVc)
  );

  function automatic int clsOf(int i);
    return int'(reqClass[i*3 +: 3]);
  endfunction

  // expected grants from the requirements (R2..R10)
  task automatic computeExp();
    bit anyWr = 0;
    for (int i = 0; i < NI; i++) if (reqValid[i] && clsOf(i) == 5) anyWr = 1;
    for (int i = 0; i < NI; i++) begin
      int c = clsOf(i);
      expTgt[i] = 0; expElig[i] = 0; expGv[i] = 0;
      if (reqValid[i]) begin
        if (c == 6) begin
          expTgt[i] = 18; expElig[i] = mCred[18] > 0;
        end else if (c < 6) begin
          if (!reqInOrder[i] && mCred[3*c] > 0) expTgt[i] = 3*c;
          else expTgt[i] = 3*c + 1 + int'(reqWrapped[i]);
          expElig[i] = mCred[expTgt[i]] > 0;
          if (c == 4 && anyWr) expElig[i] = 0;
        end
      end
    end
    for (int v = 0; v < TVC; v++) begin
      bit got = 0;
      for (int k = 0; k < NI; k++) begin
        int idx = (mPtr[v] + k) % NI;
        if (!got && expElig[idx] && expTgt[idx] == v) begin
          got = 1; expGv[idx] = 1;
        end
      end
    end
  endtask

  task automatic applyModel();
    for (int v = 0; v < TVC; v++) begin
      int used = 0;
      for (int i = 0; i < NI; i++) if (expGv[i] && expTgt[i] == v) begin
        used = 1; mPtr[v] = (i + 1) % NI;
      end
      mCred[v] = mCred[v] - used + int'(creditReturn[v]);
      if (mCred[v] > CM) mCred[v] = CM;
    end
  endtask

  task automatic modelReset();
    for (int v = 0; v < TVC; v++) begin mCred[v] = CM; mPtr[v] = 0; end
  endtask

  task automatic check(string tag, int i, int gotV, int gotVc, int eV, int eVc);
    checks++;
    if (gotV != eV || (eV == 1 && gotVc != eVc)) begin
      errors++;
      $display("FAIL %s in%0d: got gv=%0d vc=%0d expected gv=%0d vc=%0d",
               tag, i, gotV, gotVc, eV, eVc);
    end
  endtask

  // explicit directed expectation, sampled mid low phase
  task automatic expect1(string tag, int i, int eV, int eVc);
    check(tag, i, int'(grantValid[i]), int'(grantVc[i*5 +: 5]), eV, eVc);
  endtask

  // model compare, then step one clock
  task automatic cycle(string tag);
    #0.5;
    computeExp();
    for (int i = 0; i < NI; i++)
      check(tag, i, int'(grantValid[i]), int'(grantVc[i*5 +: 5]), int'(expGv[i]), expTgt[i]);
    @(posedge clk);
    applyModel();
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = '0; reqInOrder = '0; reqWrapped = '0; creditReturn = '0;
  endtask

  task automatic setReq(int i, int cls, bit ord, bit wrap);
    reqValid[i] = 1'b1;
    reqClass[i*3 +: 3] = 3'(cls);
    reqInOrder[i] = ord;
    reqWrapped[i] = wrap;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all: watchdog expired, got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    rstN = 1'b0; reqClass = '0; idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1; modelReset();

    // R1 / R10: reset state, valid low with class set gives no grant
    reqClass = '1;
    #0.25; for (int i = 0; i < NI; i++) expect1("R1 R10 idle", i, 0, 0);
    cycle("R1 R10 idle");
    idle(); setReq(0, 0, 0, 0);
    #0.25; expect1("R1 R3 first adaptive", 0, 1, 0);
    cycle("R1 R3");

    // R2: channel numbering per class
    idle(); setReq(0, 6, 0, 0); setReq(1, 3, 0, 0); setReq(2, 7, 0, 0);
    #0.25; expect1("R2 special", 0, 1, 18); expect1("R2 class3", 1, 1, 9);
    expect1("R2 class7 invalid", 2, 0, 0);
    cycle("R2");

    // R3 / R4: spend class 1 adaptive, then fall back by wrap flag
    idle(); setReq(0, 1, 0, 0);
    #0.25; expect1("R3 adaptive", 0, 1, 3); cycle("R3");
    #0.25; expect1("R3 adaptive", 0, 1, 3); cycle("R3");
    #0.25; expect1("R4 escape wrap0", 0, 1, 4); cycle("R4");
    setReq(0, 1, 0, 1);
    #0.25; expect1("R4 escape wrap1", 0, 1, 5); cycle("R4");

    // R5: in-order keeps off the adaptive channel
    idle(); setReq(0, 2, 1, 0);
    #0.25; expect1("R5 in-order", 0, 1, 7); cycle("R5");

    // R6: drain class 1 completely, other classes unaffected
    idle(); setReq(0, 1, 0, 0); cycle("R6 drain");
    setReq(0, 1, 0, 1); cycle("R6 drain");
    setReq(0, 1, 0, 0); setReq(1, 0, 0, 0);
    #0.25; expect1("R6 empty class", 0, 0, 0); expect1("R6 isolation", 1, 1, 0);
    cycle("R6");

    // R7: one return restores a credit
    idle(); creditReturn[3] = 1'b1; cycle("R7 return");
    idle(); setReq(0, 1, 0, 0);
    #0.25; expect1("R7 restored", 0, 1, 3); cycle("R7");
    // R7: returns at full are ignored
    idle(); creditReturn[6] = 1'b1;
    repeat (4) cycle("R7 saturate");
    idle(); setReq(0, 2, 0, 0);
    #0.25; expect1("R7 full 1", 0, 1, 6); cycle("R7");
    #0.25; expect1("R7 full 2", 0, 1, 6); cycle("R7");
    #0.25; expect1("R7 saturated", 0, 1, 7); cycle("R7");

    // R8: I/O read held behind a write, write not held
    idle(); setReq(0, 4, 0, 0); setReq(1, 5, 0, 0);
    #0.25; expect1("R8 read held", 0, 0, 0); expect1("R8 write passes", 1, 1, 15);
    cycle("R8");
    idle(); setReq(0, 4, 0, 0);
    #0.25; expect1("R8 read released", 0, 1, 12); cycle("R8");

    // R9 / R7: contested channel, return each cycle keeps one credit
    idle(); setReq(0, 3, 0, 0); setReq(1, 3, 0, 0); setReq(2, 3, 0, 0);
    creditReturn[9] = 1'b1;
    #0.25; expect1("R9 rr first", 2, 1, 9); expect1("R9 loser", 0, 0, 0); cycle("R9");
    #0.25; expect1("R9 rr wrap", 0, 1, 9); cycle("R9");
    #0.25; expect1("R9 rr next", 1, 1, 9); cycle("R9");

    // constrained random mix, all requirements
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int i = 0; i < NI; i++) begin
        if ($urandom % 4 != 0) setReq(i, int'($urandom % 8), 1'($urandom % 4 == 0), 1'($urandom % 2));
      end
      for (int v = 0; v < TVC; v++) creditReturn[v] = ($urandom % 3 == 0);
      cycle("R2-R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule